// File: doc/BRIEF.md
# Clock Time Register Freeze and Reload Controller

This block sits between a set of free-running timekeeping counters and the bank of time registers that software sees, from the seconds register up to the centuries register. When idle, the visible bank follows the counters. On each update tick it takes a fresh copy of their values, so a read of the bank returns the current time.

Two control bits change this. The read-freeze bit holds the visible bank steady so that a read across several registers sees one consistent instant. The write-freeze bit also holds the bank steady, and it opens the bank to bus writes so that software can compose a new base time. When the write-freeze bit is cleared, the block copies the composed time into the counters with a single load strobe. It does this only if at least one time register was actually written during that window. The centuries register, like the others, carries two BCD digits (00 to 99), with the units digit in bits 3:0 and the tens digit above it. The block passes every register value through unaltered.

Top module: `rtc_snap_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, every visible time register reads 0x00 and the load strobe is low.
- R2: When neither freeze bit is set and no load is in progress, a high update tick copies all counter values into the visible registers at the next clock edge. With the tick low, the registers keep their value.
- R3: While the read-freeze bit is 1, the visible registers ignore ticks and counter changes, whether or not the write-freeze bit is set. Once it returns to 0, the next tick refreshes them.
- R4: While the write-freeze bit is 1, the visible registers ignore ticks, and a bus write stores its data byte into the addressed register at the next edge.
- R5: A bus write made while the write-freeze bit is 0 changes no register and causes no load.
- R6: If a time register was written during a write-freeze window, then the edge that first samples the write-freeze bit at 0 starts a load strobe. That strobe is high for exactly one cycle, and while it is high the load data carries the full visible bank, with register n in bits 8n+7:8n.
- R7: A write-freeze window without any bus write produces no load strobe.
- R8: With both freeze bits set, clearing only the read-freeze bit does not resume tracking. Tracking resumes only after the write-freeze bit is also 0.
- R9: The visible registers keep the written time, ignoring ticks, in the cycle in which the write-freeze bit falls and in the load strobe cycle. Tracking resumes on the edge after the strobe.
- R10: The record that a time register was written is cleared by the window close. A following window with no write therefore produces no load.
- R11: The read data output shows the register selected by the read/write address combinationally; address n selects register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Update tick from the counters, one clock wide |
| cnt_time_i | input | NUM_REGS*REG_W | Counter values, register n in bits n*REG_W upward |
| rd_freeze_i | input | 1 | Read-freeze control bit |
| wr_freeze_i | input | 1 | Write-freeze control bit |
| bus_wr_i | input | 1 | Register write request |
| bus_addr_i | input | ADDR_W | Register index for write and read |
| bus_wdata_i | input | REG_W | Write data byte |
| bus_rdata_o | output | REG_W | Read data of the addressed register |
| load_o | output | 1 | One-cycle load strobe to the counters |
| load_data_o | output | NUM_REGS*REG_W | New base time for the counters |

## Verification
The assertions check, on every cycle, that the bank stays still while frozen, follows the counters on an unfrozen tick, and accepts each write into the addressed register. They also check that a write without the write-freeze bit leaves the bank alone, that the strobe is never longer than one cycle, and that it never fires for a clean window. Only the bench's scenarios can show the ordering across whole windows. That ordering covers the exact cycle of the strobe, the load data matching every byte written earlier, the bank holding through the close of the window and then tracking again, and the two-bit release order when both freeze bits were set.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int unsigned DEF_REGS  = 8;
  localparam int unsigned DEF_REG_W = 8;

  typedef struct packed {
    logic w_q;
    logic dirty_q;
    logic load_q;
  } ld_state_t;
endpackage

// File: rtl/rtc_snap_rstsync.sv
module rtc_snap_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rtc_snap_ldctl.sv
module rtc_snap_ldctl
  import rtc_snap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_freeze_i,
  input  logic wr_hit_i,
  output logic w_q_o,
  output logic load_o
);
  ld_state_t state_q, state_d;
  logic      fall;

  always_comb begin
    fall            = state_q.w_q & ~wr_freeze_i;
    state_d.w_q     = wr_freeze_i;
    state_d.dirty_q = fall ? 1'b0 : (state_q.dirty_q | wr_hit_i);
    state_d.load_q  = fall & state_q.dirty_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign w_q_o  = state_q.w_q;
  assign load_o = state_q.load_q;

  // R6: strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q.load_q |=> !state_q.load_q);
  // R6: a strobe always follows a recorded write
  a_r6_needs_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q.load_q) |-> $past(state_q.dirty_q));
  // R7: clean window closes without a load
  a_r7_clean_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q.w_q && !wr_freeze_i && !state_q.dirty_q) |=> !state_q.load_q);
  // R10: write record is gone by the time the strobe is out
  a_r10_dirty_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q.load_q |-> !state_q.dirty_q);
endmodule

// File: rtl/rtc_snap_hold.sv
module rtc_snap_hold #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      freeze_i,
  input  logic                      tick_i,
  input  logic [NUM_REGS*REG_W-1:0] cnt_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic [NUM_REGS*REG_W-1:0] hold_o
);
  logic take_cnt;
  assign take_cnt = ~freeze_i & tick_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] hold_q, hold_d;
    logic             sel, en;

    always_comb begin
      sel    = wr_en_i & (wr_addr_i == ADDR_W'(g));
      en     = sel | take_cnt;
      hold_d = sel ? wr_data_i : cnt_i[g*REG_W +: REG_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  hold_q <= '0;
      else if (en)  hold_q <= hold_d;
    end

    assign hold_o[g*REG_W +: REG_W] = hold_q;

    // R4: an accepted write lands in its register
    a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == ADDR_W'(g)) |=> (hold_q == $past(wr_data_i)));
  end

  // R3: frozen bank does not move without a write
  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_en_i) |=> $stable(hold_o));
  // R2: unfrozen tick copies the counters
  a_r2_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && tick_i && !wr_en_i) |=> (hold_o == $past(cnt_i)));
endmodule

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned REG_W    = DEF_REG_W,
  parameter int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [NUM_REGS*REG_W-1:0] cnt_time_i,
  input  logic                      rd_freeze_i,
  input  logic                      wr_freeze_i,
  input  logic                      bus_wr_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [REG_W-1:0]          bus_wdata_i,
  output logic [REG_W-1:0]          bus_rdata_o,
  output logic                      load_o,
  output logic [NUM_REGS*REG_W-1:0] load_data_o
);
  localparam int unsigned CMP_W = ADDR_W + 1;

  logic                      rst_n;
  logic                      addr_ok, wr_hit, w_q, freeze;
  logic [NUM_REGS*REG_W-1:0] hold;

  rtc_snap_rstsync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign addr_ok = ({1'b0, bus_addr_i} < CMP_W'(NUM_REGS));
  assign wr_hit  = bus_wr_i & wr_freeze_i & addr_ok;

  rtc_snap_ldctl u_ld (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_freeze_i (wr_freeze_i),
    .wr_hit_i    (wr_hit),
    .w_q_o       (w_q),
    .load_o      (load_o)
  );

  assign freeze = rd_freeze_i | wr_freeze_i | w_q | load_o;

  rtc_snap_hold #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .freeze_i  (freeze),
    .tick_i    (tick_i),
    .cnt_i     (cnt_time_i),
    .wr_en_i   (wr_hit),
    .wr_addr_i (bus_addr_i),
    .wr_data_i (bus_wdata_i),
    .hold_o    (hold)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (bus_addr_i == ADDR_W'(i)) bus_rdata_o = hold[i*REG_W +: REG_W];
    end
  end

  assign load_data_o = hold;

  // R5: writes without the write-freeze bit change nothing
  a_r5_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && !wr_freeze_i && !tick_i) |=> $stable(hold));
  // R8: write-freeze alone keeps the bank still
  a_r8_w_alone_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_freeze_i && !rd_freeze_i && !bus_wr_i) |=> $stable(hold));
  // R9: bank does not move during the strobe cycle
  a_r9_hold_at_load: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_o && !wr_hit) |=> $stable(hold));
  // R6: strobe only after the write-freeze bit was high
  a_r6_after_window: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(load_o) |-> ($past(w_q) && !$past(wr_freeze_i)));
endmodule

// File: tb/rtc_snap_ctrl_tb_top.sv
module rtc_snap_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni, tick_i, rd_freeze_i, wr_freeze_i, bus_wr_i, load_o;
  logic [N*W-1:0] cnt_time_i, load_data_o;
  logic [AW-1:0]  bus_addr_i;
  logic [W-1:0]   bus_wdata_i, bus_rdata_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  rtc_snap_ctrl dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .cnt_time_i  (cnt_time_i),
    .rd_freeze_i (rd_freeze_i),
    .wr_freeze_i (wr_freeze_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .load_o      (load_o),
    .load_data_o (load_data_o)
  );

  function automatic logic [W-1:0] pat(input int k, input int i);
    return W'((k * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [N*W-1:0] pat_vec(input int k);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = pat(k, i);
    return v;
  endfunction

  function automatic logic [W-1:0] wv(input int i);
    return W'((i * 16 + 9) ^ 8'h5A);
  endfunction

  function automatic logic [N*W-1:0] wv_vec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = wv(i);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // R11: each address shows its own register
  task automatic check_regs(input string tag, input logic [N*W-1:0] exp);
    for (int a = 0; a < N; a++) begin
      bus_addr_i = AW'(a);
      #0.1;
      chk($sformatf("%s R11 addr%0d", tag, a), {{(N-1)*W{1'b0}}, bus_rdata_o},
          {{(N-1)*W{1'b0}}, exp[a*W +: W]});
    end
  endtask

  initial begin
    #1600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; rd_freeze_i = 1'b0; wr_freeze_i = 1'b0;
    bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0; cnt_time_i = pat_vec(0);
    step(); step(); step();
    check_regs("R1 reset", '0);
    chk("R1 load in reset", N*W'(load_o), '0);
    rst_ni = 1'b1;
    step();
    check_regs("R1 after release", '0);
    step(); step();

    // R2: tracking under many counter patterns
    for (int k = 1; k <= 12; k++) begin
      cnt_time_i = pat_vec(k); tick_i = 1'b1;
      step();
      tick_i = 1'b0;
      check_regs($sformatf("R2 track k%0d", k), pat_vec(k));
    end
    cnt_time_i = pat_vec(20);
    step(); step();
    check_regs("R2 no tick", pat_vec(12));

    // R3: read freeze
    rd_freeze_i = 1'b1;
    step();
    for (int k = 21; k <= 24; k++) begin
      cnt_time_i = pat_vec(k); tick_i = 1'b1;
      step();
    end
    tick_i = 1'b0;
    check_regs("R3 frozen", pat_vec(12));
    rd_freeze_i = 1'b0; cnt_time_i = pat_vec(25); tick_i = 1'b1;
    step();
    tick_i = 1'b0;
    check_regs("R3 resume", pat_vec(25));

    // R5: writes with write-freeze low
    for (int a = 0; a < N; a++) begin
      bus_wr_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = ~pat(25, a);
      step();
      chk("R5 no load", N*W'(load_o), '0);
    end
    bus_wr_i = 1'b0;
    step();
    check_regs("R5 ignored", pat_vec(25));
    chk("R5 no load after", N*W'(load_o), '0);

    // R4: write window, counters moving underneath
    wr_freeze_i = 1'b1;
    step();
    cnt_time_i = pat_vec(30); tick_i = 1'b1;
    for (int a = 0; a < N; a++) begin
      bus_wr_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = wv(a);
      step();
    end
    bus_wr_i = 1'b0;
    step();
    check_regs("R4 written", wv_vec());
    chk("R4 no load yet", N*W'(load_o), '0);

    // R6 / R9: close window with tick still high
    wr_freeze_i = 1'b0;
    step();
    chk("R6 strobe", N*W'(load_o), N*W'(1));
    chk("R6 load data", load_data_o, wv_vec());
    check_regs("R9 close cycle", wv_vec());
    step();
    chk("R6 single cycle", N*W'(load_o), '0);
    check_regs("R9 strobe cycle", wv_vec());
    step();
    check_regs("R9 tracking again", pat_vec(30));
    tick_i = 1'b0;

    // R7 / R10: empty window after a loaded one
    wr_freeze_i = 1'b1;
    step(); step();
    wr_freeze_i = 1'b0;
    step();
    chk("R10 no load", N*W'(load_o), '0);
    step();
    chk("R7 no load", N*W'(load_o), '0);

    // R8: both bits set, release order
    rd_freeze_i = 1'b1; wr_freeze_i = 1'b1;
    step();
    rd_freeze_i = 1'b0; cnt_time_i = pat_vec(40); tick_i = 1'b1;
    step(); step(); step();
    check_regs("R8 W still holds", pat_vec(30));
    wr_freeze_i = 1'b0;
    step();
    check_regs("R8 close cycle", pat_vec(30));
    step();
    check_regs("R8 resumed", pat_vec(40));
    chk("R8 no load", N*W'(load_o), '0);
    tick_i = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule